// File: doc/BRIEF.md
# Sector Page-Program Engine

This block sits between a flash command decoder and a flash array. Byte writes are gathered into a buffer that holds one sector, called the page. The engine works out when loading has finished, either because no byte arrived within a set window or because the host read the device. It then runs a timed programming cycle. In the final part of that cycle it streams the page into the array write port, one byte per clock. While a page is loading or burning, reads are answered with polling status rather than array data.

The command decoder sends two kinds of request pulse: turn write protection on, and turn it off. Either pulse puts the engine into an armed state. The next data write then loads a page even when protection is on. The requested protection change is reported only at the end of a burn that completes. The array storage, the protection flag register and command decoding all live outside the block.

Top module: `page_prog_engine`

## Requirements
- R1: After reset the engine is idle. `cmt_we`, `sdp_upd` and `stat_vld` are low, and the polling toggle bit is 0.
- R2: A write starts a page load in two cases: from idle when `sdp_on` is low, or from the armed state. A write in idle while `sdp_on` is high is ignored.
- R3: Starting a load sets every page byte to all ones before the written byte is stored, so unwritten page bytes are committed as 0xFF.
- R4: Each byte stored while loading restarts a window of `WIN_CYC` cycles. If no byte arrives before it expires, the burn begins. The armed state also times out after `WIN_CYC` cycles and returns to idle.
- R5: A burn lasts `BURN_CYC` cycles. In its last `PAGE_BYTES` cycles, `cmt_we` is high and the page is written out in ascending index order. The sector used is the one holding the last written address, so `cmt_addr` = that sector concatenated with the byte index.
- R6: While loading, a write to a different sector cancels the load and drops any pending protection change. The write is then handled as if the engine were idle, so it starts a new page only when `sdp_on` is low.
- R7: When `lock_lo` is set, a write below `BOOT_BYTES` does not start a load. When `lock_hi` is set, a write at or above `2^ADDR_W - BOOT_BYTES` does not start a load. From the armed state, such a write returns the engine to idle.
- R8: A read while loading starts the burn at once. A read while armed cancels back to idle.
- R9: A read while loading or burning sets `stat_vld` one cycle later. Its `stat_data` bit 1 alternates on each such read, starting from 0. Bit 0 is the inverse of bit 0 of the last stored byte when the read address equals the last written address, and 0 otherwise. The remaining bits are 0. Reads in idle or armed give `stat_vld` low.
- R10: A pending protection change is signalled only by a one-cycle `sdp_upd` pulse, in the final commit cycle of a completed burn. `sdp_val` is 1 for an enable request and 0 for a disable request.
- R11: An arm pulse in any state abandons the current operation and enters the armed state, with its request pending. An enable pulse wins over a disable pulse given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | DW | Write data |
| sdp_on | input | 1 | Write protection currently active |
| lock_lo | input | 1 | Lowest boot region is locked |
| lock_hi | input | 1 | Highest boot region is locked |
| arm_sdp_on | input | 1 | Pulse: protection-enable command accepted |
| arm_sdp_off | input | 1 | Pulse: protection-disable command accepted |
| cmt_we | output | 1 | Array write strobe during commit |
| cmt_addr | output | ADDR_W | Array byte address being committed |
| cmt_data | output | DW | Array byte being committed |
| sdp_upd | output | 1 | Apply the pending protection change |
| sdp_val | output | 1 | New protection value when `sdp_upd` is high |
| stat_vld | output | 1 | Polling status is valid this cycle |
| stat_data | output | DW | Polling status byte |

## Verification
Three results have fixed latencies after their stimulus:
- Polling status appears in the cycle after the read edge.
- The first commit byte appears `WIN_CYC + BURN_CYC - PAGE_BYTES` cycles after the edge of the last write when the window expires, or `BURN_CYC - PAGE_BYTES` cycles after a read that starts the burn.
- The protection pulse coincides with the last commit byte.

Inputs are changed just after a rising edge, and outputs are compared in the middle of every cycle against a reference model advanced at each edge. The directed checks measure these latencies as edge counts. Cancellation and ignored-write cases are checked through the commit port and the protection pulse, after enough cycles for any burn to have finished.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_LOAD  = 2'd2,
      ST_BURN  = 2'd3
   } pp_state_t;

   typedef enum logic [1:0] {
      PD_NONE = 2'd0,
      PD_SET  = 2'd1,
      PD_CLR  = 2'd2
   } pp_pend_t;
endpackage

// File: rtl/pp_cycle_counter.sv
module pp_cycle_counter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer #(
   parameter int PAGE_BYTES = 256,
   parameter int DW         = 8,
   localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             fill,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [DW-1:0]    wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] mem [PAGE_BYTES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
         if (we && widx == IDX_W'(i)) mem[i] <= wdata;
         else if (fill)               mem[i] <= '1;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/pp_status.sv
module pp_status #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_hit,
   input  logic          at_last,
   input  logic          last_b0,
   output logic          stat_vld,
   output logic [DW-1:0] stat_data
);
   logic tog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog       <= 1'b0;
         stat_vld  <= 1'b0;
         stat_data <= '0;
      end else if (rd_hit) begin
         tog       <= ~tog;
         stat_vld  <= 1'b1;
         stat_data <= {{(DW-2){1'b0}}, tog, at_last & ~last_b0};
      end else begin
         stat_vld  <= 1'b0;
         stat_data <= '0;
      end
   end
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
   import pp_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int DW         = 8,
   parameter int PAGE_BYTES = 256,
   parameter int BOOT_BYTES = 16384,
   parameter int WIN_CYC    = 37500,
   parameter int BURN_CYC   = 1750000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              sdp_on,
   input  logic              lock_lo,
   input  logic              lock_hi,
   input  logic              arm_sdp_on,
   input  logic              arm_sdp_off,
   output logic              cmt_we,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [DW-1:0]     cmt_data,
   output logic              sdp_upd,
   output logic              sdp_val,
   output logic              stat_vld,
   output logic [DW-1:0]     stat_data
);
   localparam int IDX_W     = $clog2(PAGE_BYTES);
   localparam int MAX_CYC   = (WIN_CYC > BURN_CYC) ? WIN_CYC : BURN_CYC;
   localparam int CW        = $clog2(MAX_CYC + 1);
   localparam int STREAM_AT = BURN_CYC - PAGE_BYTES;
   localparam int HI_BASE   = (1 << ADDR_W) - BOOT_BYTES;

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (BURN_CYC < PAGE_BYTES) begin : g_bad_burn
      $error("BURN_CYC must cover the commit stream");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("WIN_CYC must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (ADDR_W <= IDX_W || ADDR_W > 30 || 2 * BOOT_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("address width does not fit page or boot regions");
   end

   pp_state_t         st, st_n;
   pp_pend_t          pend, pend_n;
   logic [CW-1:0]     cnt;
   logic [ADDR_W-1:0] last_addr;
   logic              last_b0;
   logic              cnt_clr, fill, store;
   logic              arm_any, lock_hit, same_sec, hit_win, hit_burn, rd_hit;
   logic [IDX_W-1:0]  rd_idx;

   if (BOOT_BYTES > 0) begin : g_lock
      assign lock_hit = (lock_lo && addr <  ADDR_W'(BOOT_BYTES)) ||
                        (lock_hi && addr >= ADDR_W'(HI_BASE));
   end else begin : g_nolock
      assign lock_hit = 1'b0;
   end

   assign arm_any  = arm_sdp_on | arm_sdp_off;
   assign same_sec = addr[ADDR_W-1:IDX_W] == last_addr[ADDR_W-1:IDX_W];
   assign hit_win  = cnt == CW'(WIN_CYC - 1);
   assign hit_burn = cnt == CW'(BURN_CYC - 1);

   always_comb begin
      st_n    = st;
      pend_n  = pend;
      cnt_clr = 1'b0;
      fill    = 1'b0;
      store   = 1'b0;
      // timed progress
      case (st)
         ST_ARMED: if (hit_win)  begin st_n = ST_IDLE; pend_n = PD_NONE; end
         ST_LOAD:  if (hit_win)  begin st_n = ST_BURN; cnt_clr = 1'b1; end
         ST_BURN:  if (hit_burn) begin st_n = ST_IDLE; pend_n = PD_NONE; end
         default: ;
      endcase
      // host events override the timers
      if (arm_any) begin
         st_n    = ST_ARMED;
         pend_n  = arm_sdp_on ? PD_SET : PD_CLR;
         cnt_clr = 1'b1;
      end else if (wr_en) begin
         case (st)
            ST_IDLE: if (!sdp_on && !lock_hit) begin
               st_n = ST_LOAD; fill = 1'b1; store = 1'b1; cnt_clr = 1'b1;
            end
            ST_ARMED: if (lock_hit) begin
               st_n = ST_IDLE; pend_n = PD_NONE;
            end else begin
               st_n = ST_LOAD; fill = 1'b1; store = 1'b1; cnt_clr = 1'b1;
            end
            ST_LOAD: if (same_sec) begin
               st_n = ST_LOAD; store = 1'b1; cnt_clr = 1'b1;
            end else begin
               pend_n = PD_NONE;
               if (!sdp_on && !lock_hit) begin
                  st_n = ST_LOAD; fill = 1'b1; store = 1'b1; cnt_clr = 1'b1;
               end else begin
                  st_n = ST_IDLE;
               end
            end
            default: ;
         endcase
      end else if (rd_en) begin
         if (st == ST_ARMED) begin
            st_n = ST_IDLE; pend_n = PD_NONE;
         end else if (st == ST_LOAD) begin
            st_n = ST_BURN; cnt_clr = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         pend      <= PD_NONE;
         last_addr <= '0;
         last_b0   <= 1'b0;
      end else begin
         st   <= st_n;
         pend <= pend_n;
         if (store) begin
            last_addr <= addr;
            last_b0   <= wdata[0];
         end
      end
   end

   pp_cycle_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(st != ST_IDLE), .clr(cnt_clr), .cnt(cnt)
   );

   assign rd_idx = IDX_W'(cnt - CW'(STREAM_AT));

   pp_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_buf (
      .clk(clk), .fill(fill), .we(store), .widx(addr[IDX_W-1:0]),
      .wdata(wdata), .ridx(rd_idx), .rdata(cmt_data)
   );

   assign rd_hit = rd_en && !wr_en && !arm_any && (st == ST_LOAD || st == ST_BURN);

   pp_status #(.DW(DW)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .at_last(addr == last_addr),
      .last_b0(last_b0), .stat_vld(stat_vld), .stat_data(stat_data)
   );

   assign cmt_we   = st == ST_BURN && cnt >= CW'(STREAM_AT) && !arm_any;
   assign cmt_addr = {last_addr[ADDR_W-1:IDX_W], rd_idx};
   assign sdp_upd  = st == ST_BURN && hit_burn && !arm_any && pend != PD_NONE;
   assign sdp_val  = sdp_upd && pend == PD_SET;
endmodule

// File: rtl/pp_engine_checks.sv
module pp_engine_checks #(
   parameter int ADDR_W = 19,
   parameter int DW     = 8,
   parameter int IDX_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              cmt_we,
   input logic [ADDR_W-1:0] cmt_addr,
   input logic              sdp_upd,
   input logic              stat_vld,
   input logic [DW-1:0]     stat_data
);
   logic seen, prev_b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen    <= 1'b0;
         prev_b1 <= 1'b0;
      end else if (stat_vld) begin
         seen    <= 1'b1;
         prev_b1 <= stat_data[1];
      end
   end

   AST_STAT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> $past(rd_en)); // R9
   AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vld && seen) |-> stat_data[1] != prev_b1); // R9
   AST_CMT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_we && $past(cmt_we)) |-> cmt_addr == $past(cmt_addr) + ADDR_W'(1)); // R5
   AST_CMT_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmt_we) |-> cmt_addr[IDX_W-1:0] == '0); // R5
   AST_SDP_ON_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      sdp_upd |-> (cmt_we && &cmt_addr[IDX_W-1:0])); // R10
   AST_SDP_ENDS_BURN: assert property (@(posedge clk) disable iff (!rst_n)
      sdp_upd |=> !cmt_we); // R10
endmodule

bind page_prog_engine pp_engine_checks #(.ADDR_W(ADDR_W), .DW(DW), .IDX_W(IDX_W)) u_checks (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cmt_we(cmt_we), .cmt_addr(cmt_addr),
   .sdp_upd(sdp_upd), .stat_vld(stat_vld), .stat_data(stat_data)
);

// File: tb/page_prog_engine_test.sv
module page_prog_engine_test;
   localparam int AW = 10, PG = 16, BOOT = 64, WIN = 12, BURN = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, sdp_on = 0, lock_lo = 0, lock_hi = 0, arm_on = 0, arm_off = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic cmt_we, sdp_upd, sdp_val, stat_vld;
   logic [AW-1:0] cmt_addr;
   logic [7:0] cmt_data, stat_data;

   always #2 clk = ~clk;

   page_prog_engine #(.ADDR_W(AW), .DW(8), .PAGE_BYTES(PG), .BOOT_BYTES(BOOT),
                      .WIN_CYC(WIN), .BURN_CYC(BURN)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .sdp_on(sdp_on), .lock_lo(lock_lo), .lock_hi(lock_hi), .arm_sdp_on(arm_on),
      .arm_sdp_off(arm_off), .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
      .sdp_upd(sdp_upd), .sdp_val(sdp_val), .stat_vld(stat_vld), .stat_data(stat_data));

   int errors = 0, checks = 0, cyc = 0;
   int n_cmt = 0, n_upd = 0, last_upd_val = -1, first_cmt = 0, op_cyc = 0;
   int shadow [1024];
   logic prev_we = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model: 0 idle, 1 armed, 2 loading, 3 burning; pending 0 none, 1 on, 2 off
   int m_st = 0, m_cnt = 0, m_last = 0, m_b0 = 0, m_pend = 0, m_tog = 0, m_sv = 0, m_sd = 0;
   int m_buf [PG];

   function automatic bit locked(input int a);
      return (lock_lo && a < BOOT) || (lock_hi && a >= 1024 - BOOT);
   endfunction

   task automatic m_store(input bit fresh);
      if (fresh) for (int i = 0; i < PG; i++) m_buf[i] = 255;
      m_buf[int'(addr) % PG] = int'(wdata);
      m_last = int'(addr);
      m_b0 = int'(wdata[0]);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_pend = 0; m_tog = 0; m_sv = 0; m_sd = 0; m_last = 0; m_b0 = 0;
      end else begin
         int nst, ncnt;
         bit arm, clr;
         arm = arm_on || arm_off;
         nst = m_st; clr = 0;
         ncnt = (m_st != 0) ? m_cnt + 1 : m_cnt;
         if (rd_en && !wr_en && !arm && (m_st == 2 || m_st == 3)) begin
            m_sv = 1;
            m_sd = m_tog * 2 + ((int'(addr) == m_last) ? (1 - m_b0) : 0);
            m_tog = 1 - m_tog;
         end else begin
            m_sv = 0; m_sd = 0;
         end
         if (m_st == 1 && m_cnt == WIN - 1) begin nst = 0; m_pend = 0; end
         if (m_st == 2 && m_cnt == WIN - 1) begin nst = 3; clr = 1; end
         if (m_st == 3 && m_cnt == BURN - 1) begin nst = 0; m_pend = 0; end
         if (arm) begin
            nst = 1; m_pend = arm_on ? 1 : 2; clr = 1;
         end else if (wr_en) begin
            if (m_st == 0 && !sdp_on && !locked(int'(addr))) begin
               nst = 2; m_store(1); clr = 1;
            end else if (m_st == 1) begin
               if (locked(int'(addr))) begin nst = 0; m_pend = 0; end
               else begin nst = 2; m_store(1); clr = 1; end
            end else if (m_st == 2) begin
               if (int'(addr) / PG == m_last / PG) begin m_store(0); clr = 1; end
               else begin
                  m_pend = 0;
                  if (!sdp_on && !locked(int'(addr))) begin m_store(1); clr = 1; end
                  else nst = 0;
               end
            end
         end else if (rd_en) begin
            if (m_st == 1) begin nst = 0; m_pend = 0; end
            else if (m_st == 2) begin nst = 3; clr = 1; end
         end
         m_st = nst;
         m_cnt = clr ? 0 : ncnt;
      end
   end

   // mid-cycle comparison against the model, plus shadow array of committed bytes
   always @(negedge clk) if (rst_n) begin
      bit arm, e_we, e_upd;
      int idx;
      arm = arm_on || arm_off;
      e_we = (m_st == 3) && (m_cnt >= BURN - PG) && !arm;
      e_upd = (m_st == 3) && (m_cnt == BURN - 1) && !arm && (m_pend != 0);
      idx = m_cnt - (BURN - PG);
      chk(cmt_we == e_we, "R5 cmt_we", int'(cmt_we), int'(e_we));
      if (e_we && cmt_we) begin
         chk(int'(cmt_addr) == (m_last / PG) * PG + idx, "R5 cmt_addr", int'(cmt_addr), (m_last / PG) * PG + idx);
         chk(int'(cmt_data) == m_buf[idx], "R3 cmt_data", int'(cmt_data), m_buf[idx]);
      end
      chk(sdp_upd == e_upd, "R10 sdp_upd", int'(sdp_upd), int'(e_upd));
      if (e_upd && sdp_upd) chk(int'(sdp_val) == ((m_pend == 1) ? 1 : 0), "R10 sdp_val", int'(sdp_val), (m_pend == 1) ? 1 : 0);
      chk(int'(stat_vld) == m_sv, "R9 stat_vld", int'(stat_vld), m_sv);
      chk(int'(stat_data) == m_sd, "R9 stat_data", int'(stat_data), m_sd);
      if (cmt_we) begin
         shadow[cmt_addr] = int'(cmt_data);
         n_cmt++;
         if (!prev_we) first_cmt = cyc;
      end
      if (sdp_upd) begin n_upd++; last_upd_val = int'(sdp_val); end
      prev_we = cmt_we;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_wr(input int a, input int d);
      @(posedge clk); #1;
      wr_en = 1; addr = AW'(a); wdata = 8'(d);
      @(posedge clk); #1;
      op_cyc = cyc; wr_en = 0;
   endtask

   task automatic do_rd(input int a, output int sv, output int sd);
      @(posedge clk); #1;
      rd_en = 1; addr = AW'(a);
      @(posedge clk); #1;
      op_cyc = cyc; rd_en = 0;
      @(negedge clk);
      sv = int'(stat_vld); sd = int'(stat_data);
   endtask

   task automatic do_arm(input bit on);
      @(posedge clk); #1;
      if (on) arm_on = 1; else arm_off = 1;
      @(posedge clk); #1;
      arm_on = 0; arm_off = 0;
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int c0, u0, sv, sd;
      for (int i = 0; i < 1024; i++) shadow[i] = -1;
      wait_cyc(4);
      #1 rst_n = 1;
      @(negedge clk);
      chk(!cmt_we && !sdp_upd && !stat_vld, "R1 reset outputs", int'({cmt_we, sdp_upd, stat_vld}), 0);

      // R2: write ignored while protected and idle
      sdp_on = 1; c0 = n_cmt;
      do_wr(16'h105, 8'h3C); wait_cyc(70);
      chk(n_cmt == c0, "R2 protected write ignored", n_cmt - c0, 0);

      // R3 R4 R5: direct load, window timeout, commit
      sdp_on = 0; c0 = n_cmt;
      do_wr(16'h123, 8'hA5);
      do_wr(16'h12A, 8'h5A);
      u0 = op_cyc;
      wait_cyc(70);
      chk(first_cmt - u0 == WIN + BURN - PG, "R4 window then burn latency", first_cmt - u0, WIN + BURN - PG);
      chk(n_cmt - c0 == PG, "R5 commit length", n_cmt - c0, PG);
      chk(shadow[16'h123] == 8'hA5, "R5 byte a", shadow[16'h123], 8'hA5);
      chk(shadow[16'h12A] == 8'h5A, "R5 byte b", shadow[16'h12A], 8'h5A);
      chk(shadow[16'h120] == 8'hFF, "R3 unwritten byte", shadow[16'h120], 8'hFF);

      // R8 R9: read starts burn, polling status
      do_wr(16'h207, 8'h10);
      do_rd(16'h207, sv, sd);
      u0 = op_cyc;
      chk(sv == 1 && sd == 1, "R9 first poll at last addr", sd, 1);
      do_rd(16'h200, sv, sd);
      chk(sv == 1 && sd == 2, "R9 second poll other addr", sd, 2);
      do_rd(16'h207, sv, sd);
      chk(sv == 1 && sd == 1, "R9 third poll at last addr", sd, 1);
      wait_cyc(60);
      chk(first_cmt - u0 == BURN - PG, "R8 read starts burn", first_cmt - u0, BURN - PG);
      chk(shadow[16'h207] == 8'h10, "R8 committed byte", shadow[16'h207], 8'h10);
      do_rd(16'h207, sv, sd);
      chk(sv == 0, "R9 idle read no status", sv, 0);

      // R10 R11 R2: armed enable, write under protection, pulse at end
      sdp_on = 1; u0 = n_upd;
      do_arm(1);
      do_wr(16'h300, 8'h77);
      wait_cyc(70);
      chk(shadow[16'h300] == 8'h77, "R2 armed write loads", shadow[16'h300], 8'h77);
      chk(n_upd - u0 == 1 && last_upd_val == 1, "R10 enable applied at end", last_upd_val, 1);

      // R4: armed timeout
      do_arm(0); wait_cyc(20);
      c0 = n_cmt; u0 = n_upd;
      do_wr(16'h310, 8'h99); wait_cyc(70);
      chk(n_cmt == c0 && n_upd == u0, "R4 armed state times out", n_cmt - c0, 0);

      // R8: read while armed cancels
      do_arm(0);
      do_rd(16'h000, sv, sd);
      chk(sv == 0, "R8 armed read gives no status", sv, 0);
      do_wr(16'h320, 8'h44); wait_cyc(70);
      chk(shadow[16'h320] == -1 && n_upd == u0, "R8 armed read cancels", shadow[16'h320], -1);

      // R6: sector change cancels and drops pending
      do_arm(0);
      do_wr(16'h330, 8'h12);
      do_wr(16'h345, 8'h34); wait_cyc(70);
      chk(shadow[16'h330] == -1 && shadow[16'h345] == -1, "R6 cancel under protection", shadow[16'h345], -1);
      chk(n_upd == u0, "R6 pending dropped", n_upd - u0, 0);
      sdp_on = 0;
      do_wr(16'h150, 8'h01);
      do_wr(16'h165, 8'h02); wait_cyc(70);
      chk(shadow[16'h165] == 2 && shadow[16'h160] == 8'hFF, "R6 new page started", shadow[16'h165], 2);
      chk(shadow[16'h150] == -1, "R6 old page dropped", shadow[16'h150], -1);

      // R7: boot region locks
      lock_lo = 1; lock_hi = 1; c0 = n_cmt;
      do_wr(16'h005, 8'h55); wait_cyc(70);
      do_wr(16'h03F, 8'h56); wait_cyc(70);
      do_wr(16'h3C0, 8'h57); wait_cyc(70);
      chk(n_cmt == c0, "R7 locked writes start nothing", n_cmt - c0, 0);
      do_wr(16'h040, 8'h58); wait_cyc(70);
      chk(shadow[16'h040] == 8'h58, "R7 first unlocked address", shadow[16'h040], 8'h58);
      u0 = n_upd;
      do_arm(1);
      do_wr(16'h3FF, 8'h59); wait_cyc(70);
      chk(shadow[16'h3FF] == -1 && n_upd == u0, "R7 armed locked write cancels", shadow[16'h3FF], -1);
      lock_lo = 0; lock_hi = 0;

      // R11: arm during load abandons the page
      c0 = n_cmt;
      do_wr(16'h050, 8'hAB);
      do_arm(1); wait_cyc(70);
      chk(shadow[16'h050] == -1 && n_cmt == c0, "R11 arm abandons load", n_cmt - c0, 0);
      chk(n_upd == u0, "R11 no pulse after timeout", n_upd - u0, 0);

      wait_cyc(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule